// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer Register Port

This block joins an 8-bit processor bus to four 16-bit timer registers:
- an up-counter that advances on an enable pulse,
- two output-compare registers,
- one input-capture register.

Every 16-bit value crosses the bus as two byte cycles, high byte first. A single 8-bit holding latch is shared by all four registers and keeps each transfer whole.

A write of a high byte parks that byte in the latch. The following low-byte write commits both halves at once. A read of a high byte of the counter or the capture register copies the live low byte into the latch in the same cycle. The following low-byte read returns that copy, so a counter that keeps running is still read as one consistent word. The compare registers are read straight from storage and leave the latch alone.

Each compare channel compares its register with the counter on every clock. On equality it drives its output to a level chosen by a per-channel select bit. The output keeps that level until the next match. A capture strobe copies the counter into the capture register.

Top module: `wide_timer_port`

## Requirements
- R1: After reset the counter, both compare registers, the capture register, the latch, the level-select bits and both match outputs are all 0. `rdData` is 0 whenever `rdEn` is low, `wrEn` is high, or the address is not mapped.
- R2: Byte address map:
  - 0x1: level-select register.
  - 0x2 / 0x3: counter high / low byte.
  - 0x4 / 0x5: compare A high / low byte.
  - 0x6 / 0x7: compare B high / low byte.
  - 0x8 / 0x9: capture high / low byte.

  A write to a high-byte address loads only the holding latch and leaves the target register unchanged.
- R3: A write to a low-byte address sets the whole target register to {latch, written byte} at that clock edge.
- R4: A read of the counter or capture high byte returns the register's current high byte. At the same edge the register's current low byte is stored in the latch.
- R5: A read of the counter or capture low byte returns the latch contents, not the live low byte. A counter read as high then low while it increments therefore yields the value it had at the high-byte read.
- R6: Reads of either compare register, at either byte address, return the register's own bytes and leave the latch unchanged.
- R7: Level-select register: bit 0 sets the level for channel A and bit 1 sets the level for channel B. A write stores those bits; a read returns them in the same positions, with the upper bits 0.
- R8: When the counter equals a channel's compare value, that channel's output takes the channel's selected level at the next clock edge. Otherwise the output holds its level.
- R9: With `tickEn` high the counter increments by one per clock and wraps from 0xFFFF to 0x0000. A low-byte write to the counter in the same cycle takes precedence over the increment.
- R10: With `capStrobe` high the capture register loads the current counter value at the next edge. This takes precedence over a low-byte write to the capture register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Counter increment enable |
| addr | input | 4 | Byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, combinational from address and strobe |
| capStrobe | input | 1 | Input-capture strobe |
| matchOutA | output | 1 | Compare channel A output |
| matchOutB | output | 1 | Compare channel B output |

## Verification
The checker watches these on every clock, whatever the bus is doing:
- a high-byte write touches only the latch;
- a low-byte write commits {latch, byte};
- a high-byte counter read snapshots the low byte;
- compare reads leave the latch alone;
- a match drives the selected level, and the output holds between matches;
- the counter steps by one;
- a capture loads the counter value.

Other properties depend on multi-cycle sequences and are shown only by the bench's scenarios, checked against a cycle-by-cycle reference model:
- a whole-word read stays coherent while the counter rolls from 0x00FF to 0x0100;
- the counter wraps at 0xFFFF;
- a lone high-byte write leaves the register unchanged;
- a low-byte write beats a tick, and a capture beats a low-byte write;
- the outputs follow a change of the level bits.

// File: rtl/wtp_pkg.sv
`timescale 1ns/1ps
package wtp_pkg;
  localparam int ADR_W   = 4;
  localparam int NUM_CMP = 2;

  localparam logic [ADR_W-1:0] A_LVL   = 4'h1;
  localparam logic [ADR_W-1:0] A_CNT_H = 4'h2;
  localparam logic [ADR_W-1:0] A_CNT_L = 4'h3;
  localparam logic [ADR_W-1:0] A_CPA_H = 4'h4;
  localparam logic [ADR_W-1:0] A_CPA_L = 4'h5;
  localparam logic [ADR_W-1:0] A_CPB_H = 4'h6;
  localparam logic [ADR_W-1:0] A_CPB_L = 4'h7;
  localparam logic [ADR_W-1:0] A_CAP_H = 4'h8;
  localparam logic [ADR_W-1:0] A_CAP_L = 4'h9;

  typedef enum logic [1:0] {T_CNT = 2'd0, T_CMPA = 2'd1, T_CMPB = 2'd2, T_CAP = 2'd3} tgt_e;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic snapLo;
    logic rdHi;
    logic rdLoLatch;
    logic rdLoDirect;
    logic lvlWr;
    logic lvlRd;
    tgt_e tgt;
  } busStrobe_t;
endpackage

// File: rtl/wtp_bus_ctrl.sv
`timescale 1ns/1ps
module wtp_bus_ctrl
  import wtp_pkg::*;
(
  input  logic [ADR_W-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  output busStrobe_t       stb
);
  logic hit;
  logic isLo;
  logic viaLatch;
  tgt_e tgt;

  always_comb begin
    hit  = 1'b1;
    isLo = 1'b0;
    tgt  = T_CNT;
    case (addr)
      A_CNT_H: begin tgt = T_CNT;  isLo = 1'b0; end
      A_CNT_L: begin tgt = T_CNT;  isLo = 1'b1; end
      A_CPA_H: begin tgt = T_CMPA; isLo = 1'b0; end
      A_CPA_L: begin tgt = T_CMPA; isLo = 1'b1; end
      A_CPB_H: begin tgt = T_CMPB; isLo = 1'b0; end
      A_CPB_L: begin tgt = T_CMPB; isLo = 1'b1; end
      A_CAP_H: begin tgt = T_CAP;  isLo = 1'b0; end
      A_CAP_L: begin tgt = T_CAP;  isLo = 1'b1; end
      default: hit = 1'b0;
    endcase
  end

  // counter and capture reads go through the latch; compare reads do not
  assign viaLatch = (tgt == T_CNT) || (tgt == T_CAP);

  always_comb begin
    stb     = '0;
    stb.tgt = tgt;
    if (wrEn) begin
      if (addr == A_LVL) begin
        stb.lvlWr = 1'b1;
      end else if (hit) begin
        stb.wrLo = isLo;
        stb.wrHi = !isLo;
      end
    end else if (rdEn) begin
      if (addr == A_LVL) begin
        stb.lvlRd = 1'b1;
      end else if (hit) begin
        stb.rdHi       = !isLo;
        stb.snapLo     = !isLo && viaLatch;
        stb.rdLoLatch  = isLo && viaLatch;
        stb.rdLoDirect = isLo && !viaLatch;
      end
    end
  end
endmodule

// File: rtl/wtp_datapath.sv
`timescale 1ns/1ps
module wtp_datapath
  import wtp_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int REG_W  = 2 * DATA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  busStrobe_t                      stb,
  input  logic [DATA_W-1:0]               wrData,
  input  logic                            tickEn,
  input  logic                            capStrobe,
  output logic [DATA_W-1:0]               rdData,
  output logic [NUM_CMP-1:0]              matchOut,
  output logic [REG_W-1:0]                cntQ,
  output logic [NUM_CMP-1:0][REG_W-1:0]   cmpQ,
  output logic [REG_W-1:0]                capQ,
  output logic [DATA_W-1:0]               latchQ,
  output logic [NUM_CMP-1:0]              lvlQ
);
  logic [REG_W-1:0] selVal;
  logic [REG_W-1:0] newWord;

  assign newWord = {latchQ, wrData};

  always_comb begin
    case (stb.tgt)
      T_CNT:   selVal = cntQ;
      T_CMPA:  selVal = cmpQ[0];
      T_CMPB:  selVal = cmpQ[1];
      default: selVal = capQ;
    endcase
  end

  // shared holding latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latchQ <= '0;
    else if (stb.wrHi)   latchQ <= wrData;
    else if (stb.snapLo) latchQ <= selVal[DATA_W-1:0];
  end

  // free-running counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cntQ <= '0;
    else if (stb.wrLo && stb.tgt == T_CNT) cntQ <= newWord;
    else if (tickEn)                    cntQ <= cntQ + 1'b1;
  end

  // capture register, strobe wins over a bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            capQ <= '0;
    else if (capStrobe)                    capQ <= cntQ;
    else if (stb.wrLo && stb.tgt == T_CAP) capQ <= newWord;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lvlQ <= '0;
    else if (stb.lvlWr) lvlQ <= wrData[NUM_CMP-1:0];
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam logic [1:0] MY_T = 2'(g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cmpQ[g] <= '0;
      else if (stb.wrLo && stb.tgt == MY_T) cmpQ[g] <= newWord;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                matchOut[g] <= 1'b0;
      else if (cntQ == cmpQ[g])  matchOut[g] <= lvlQ[g];
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.lvlRd)           rdData = {{(DATA_W-NUM_CMP){1'b0}}, lvlQ};
    else if (stb.rdHi)       rdData = selVal[REG_W-1:DATA_W];
    else if (stb.rdLoLatch)  rdData = latchQ;
    else if (stb.rdLoDirect) rdData = selVal[DATA_W-1:0];
  end
endmodule

// File: rtl/wide_timer_port.sv
`timescale 1ns/1ps
module wide_timer_port
  import wtp_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int REG_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [ADR_W-1:0]  addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              capStrobe,
  output logic              matchOutA,
  output logic              matchOutB
);
  busStrobe_t                    stb;
  logic [NUM_CMP-1:0]            matchOut;
  logic [REG_W-1:0]              cntQ;
  logic [NUM_CMP-1:0][REG_W-1:0] cmpQ;
  logic [REG_W-1:0]              capQ;
  logic [DATA_W-1:0]             latchQ;
  logic [NUM_CMP-1:0]            lvlQ;

  wtp_bus_ctrl u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  wtp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (wrData),
    .tickEn    (tickEn),
    .capStrobe (capStrobe),
    .rdData    (rdData),
    .matchOut  (matchOut),
    .cntQ      (cntQ),
    .cmpQ      (cmpQ),
    .capQ      (capQ),
    .latchQ    (latchQ),
    .lvlQ      (lvlQ)
  );

  assign matchOutA = matchOut[0];
  assign matchOutB = matchOut[1];
endmodule

// File: rtl/wtp_chk.sv
`timescale 1ns/1ps
module wtp_chk
  import wtp_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int REG_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tickEn,
  input logic [ADR_W-1:0]  addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic              capStrobe,
  input logic              matchOutA,
  input logic [REG_W-1:0]  cntQ,
  input logic [REG_W-1:0]  cmpAQ,
  input logic [REG_W-1:0]  capQ,
  input logic [DATA_W-1:0] latchQ,
  input logic              lvlA
);
  p_hi_write_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == A_CPA_H) |=> (cmpAQ == $past(cmpAQ) && latchQ == $past(wrData)));

  p_lo_write_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == A_CPA_L) |=> cmpAQ == {$past(latchQ), $past(wrData)});

  p_hi_read_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && addr == A_CNT_H) |=> latchQ == $past(cntQ[DATA_W-1:0]));

  p_cmp_read_keeps_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && (addr == A_CPA_H || addr == A_CPA_L || addr == A_CPB_H || addr == A_CPB_L))
      |=> latchQ == $past(latchQ));

  p_match_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ == cmpAQ) |=> matchOutA == $past(lvlA));

  p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ != cmpAQ) |=> $stable(matchOutA));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !(wrEn && addr == A_CNT_L)) |=> cntQ == $past(cntQ) + 1'b1);

  p_capture_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capStrobe |=> capQ == $past(cntQ));
endmodule

bind wide_timer_port wtp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tickEn    (tickEn),
  .addr      (addr),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .wrData    (wrData),
  .capStrobe (capStrobe),
  .matchOutA (matchOutA),
  .cntQ      (cntQ),
  .cmpAQ     (cmpQ[0]),
  .capQ      (capQ),
  .latchQ    (latchQ),
  .lvlA      (lvlQ[0])
);

// File: tb/sim_wide_timer_port.sv
`timescale 1ns/1ps
module sim_wide_timer_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       capStrobe = 1'b0;
  logic       matchOutA;
  logic       matchOutB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  wide_timer_port u0 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .capStrobe(capStrobe),
    .matchOutA(matchOutA), .matchOutB(matchOutB)
  );

  // reference model state
  logic [15:0] mCnt, mCmpA, mCmpB, mCap;
  logic [7:0]  mLatch;
  logic [1:0]  mLvl;
  logic        mOutA, mOutB;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = '0; mCmpA = '0; mCmpB = '0; mCap = '0;
      mLatch = '0; mLvl = '0; mOutA = 1'b0; mOutB = 1'b0;
    end else begin
      logic [15:0] nCnt, nCmpA, nCmpB, nCap;
      logic [7:0]  nLatch;
      logic [1:0]  nLvl;
      logic        nOutA, nOutB;
      logic        rd;
      rd = rdEn && !wrEn;
      nCnt = mCnt; nCmpA = mCmpA; nCmpB = mCmpB; nCap = mCap;
      nLatch = mLatch; nLvl = mLvl; nOutA = mOutA; nOutB = mOutB;
      if (wrEn && (addr == 4'h2 || addr == 4'h4 || addr == 4'h6 || addr == 4'h8)) nLatch = wrData;
      else if (rd && addr == 4'h2) nLatch = mCnt[7:0];
      else if (rd && addr == 4'h8) nLatch = mCap[7:0];
      if (wrEn && addr == 4'h3) nCnt = {mLatch, wrData};
      else if (tickEn) nCnt = mCnt + 16'd1;
      if (wrEn && addr == 4'h5) nCmpA = {mLatch, wrData};
      if (wrEn && addr == 4'h7) nCmpB = {mLatch, wrData};
      if (capStrobe) nCap = mCnt;
      else if (wrEn && addr == 4'h9) nCap = {mLatch, wrData};
      if (wrEn && addr == 4'h1) nLvl = wrData[1:0];
      if (mCnt == mCmpA) nOutA = mLvl[0];
      if (mCnt == mCmpB) nOutB = mLvl[1];
      mCnt = nCnt; mCmpA = nCmpA; mCmpB = nCmpB; mCap = nCap;
      mLatch = nLatch; mLvl = nLvl; mOutA = nOutA; mOutB = nOutB;
    end
  end

  function automatic logic [7:0] expRd();
    if (wrEn || !rdEn) return 8'h00;
    case (addr)
      4'h1: return {6'b0, mLvl};
      4'h2: return mCnt[15:8];
      4'h3: return mLatch;
      4'h4: return mCmpA[15:8];
      4'h5: return mCmpA[7:0];
      4'h6: return mCmpB[15:8];
      4'h7: return mCmpB[7:0];
      4'h8: return mCap[15:8];
      4'h9: return mLatch;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag();
    if (!rdEn || wrEn) return "R1";
    case (addr)
      4'h1: return "R7";
      4'h2, 4'h8: return "R4";
      4'h3, 4'h9: return "R5";
      4'h4, 4'h5, 4'h6, 4'h7: return "R6";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk({rdTag(), " model rdData"}, 32'(rdData), 32'(expRd()));
      chk("R8 model matchOutA", 32'(matchOutA), 32'(mOutA));
      chk("R8 model matchOutB", 32'(matchOutB), 32'(mOutB));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      wrEn = 1'b0; rdEn = 1'b0; capStrobe = 1'b0;
    end
  endtask

  task automatic wrB(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
  endtask

  task automatic rdB(input logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wrEn = 1'b0; rdEn = 1'b1;
    #1 d = rdData;
  endtask

  task automatic wrW(input logic [3:0] a, input logic [15:0] v);
    wrB(a, v[15:8]);
    wrB(a + 4'h1, v[7:0]);
    idle(1);
  endtask

  task automatic rdW(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rdB(a, h);
    rdB(a + 4'h1, l);
    idle(1);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    @(posedge clk); #1;
    wrEn = 1'b0; rdEn = 1'b0; tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #1 tickEn = 1'b0;
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0]  b, hi, lo;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 matchOutA", 32'(matchOutA), 0);
    chk("R1 matchOutB", 32'(matchOutB), 0);
    rdW(4'h2, w); chk("R1 counter", 32'(w), 0);
    rdW(4'h8, w); chk("R1 capture", 32'(w), 0);
    rdB(4'h1, b); idle(1); chk("R1 level bits", 32'(b), 0);

    // R2 lone high-byte write leaves target untouched
    wrB(4'h4, 8'h12); idle(1);
    rdW(4'h4, w); chk("R2 cmpA after high write only", 32'(w), 32'h0000);
    // R3 low write commits latch + byte
    wrB(4'h5, 8'h34); idle(1);
    rdW(4'h4, w); chk("R3 cmpA commit", 32'(w), 32'h1234);

    // R6 compare reads keep the latch
    wrB(4'h2, 8'hAB);
    rdW(4'h6, w); chk("R6 cmpB direct", 32'(w), 32'h0000);
    wrB(4'h3, 8'hCD); idle(1);
    rdW(4'h2, w); chk("R6 latch survived compare read", 32'(w), 32'hABCD);

    // R9 wrap
    wrW(4'h2, 16'hFFFE);
    tick(3);
    rdW(4'h2, w); chk("R9 wrap", 32'(w), 32'h0001);
    // R9 low write overrides tick
    wrB(4'h2, 8'h10);
    @(posedge clk); #1;
    addr = 4'h3; wrData = 8'h20; wrEn = 1'b1; tickEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; tickEn = 1'b0;
    rdW(4'h2, w); chk("R9 write beats tick", 32'(w), 32'h1020);

    // R4 / R5 coherent read across 0x00FF -> 0x0100
    wrW(4'h2, 16'h00FF);
    @(posedge clk); #1;
    tickEn = 1'b1; addr = 4'h2; rdEn = 1'b1;
    #1 hi = rdData;
    @(posedge clk); #1;
    addr = 4'h3;
    #1 lo = rdData;
    tickEn = 1'b0;
    idle(1);
    chk("R4 high byte at snapshot", 32'(hi), 32'h00);
    chk("R5 low byte from latch", 32'(lo), 32'hFF);
    rdW(4'h2, w); chk("R4 counter moved on", 32'(w), 32'h0100);

    // R10 capture
    @(posedge clk); #1; capStrobe = 1'b1;
    @(posedge clk); #1; capStrobe = 1'b0;
    rdW(4'h8, w); chk("R10 capture", 32'(w), 32'h0100);
    wrB(4'h8, 8'h55);
    @(posedge clk); #1;
    addr = 4'h9; wrData = 8'h66; wrEn = 1'b1; capStrobe = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; capStrobe = 1'b0;
    rdW(4'h8, w); chk("R10 capture beats write", 32'(w), 32'h0100);
    wrB(4'h8, 8'h55); wrB(4'h9, 8'h66); idle(1);
    rdW(4'h8, w); chk("R3 capture write", 32'(w), 32'h5566);

    // R7 / R8 compare outputs
    wrW(4'h4, 16'h0010);
    wrW(4'h6, 16'h0012);
    wrB(4'h1, 8'h01); idle(1);
    rdB(4'h1, b); idle(1); chk("R7 level read", 32'(b), 32'h01);
    wrW(4'h2, 16'h000C);
    tick(10);
    idle(1);
    chk("R8 A driven high", 32'(matchOutA), 1);
    chk("R8 B driven low", 32'(matchOutB), 0);
    wrB(4'h1, 8'hFE); idle(1);
    rdB(4'h1, b); idle(1); chk("R7 level read upper bits zero", 32'(b), 32'h02);
    chk("R8 A holds without match", 32'(matchOutA), 1);
    wrW(4'h2, 16'h0010);
    wrW(4'h2, 16'h0012);
    idle(2);
    chk("R8 A follows new level", 32'(matchOutA), 0);
    chk("R8 B follows new level", 32'(matchOutB), 1);

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule